// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block sequences fixed off-time PWM current regulation for one H-bridge winding. It runs on the internal oscillator clock. While the bridge is driving, a trip from the current-sense comparator stops the drive for a fixed number of cycles. During that time the winding current recirculates in fast decay, slow decay, or fast decay followed by slow decay. A 2-bit code chooses the recirculation pattern.

After every off period, a blanking window masks the comparator. This keeps the switching spike at turn-on from causing a false trip. The same window is restarted when the direction input changes or the enable input rises. A falling enable cuts the window short. The block outputs a per-cycle drive-state code and a blanking flag, and the bridge output logic uses both.

The comparator input is asynchronous and passes through a two-flop synchroniser. The direction and enable inputs are taken as synchronous to the clock.

Top module: `offtime_chopper`

## Requirements
- R1: The drive-state code is ON = 2'b00, FAST = 2'b01, SLOW = 2'b10, and 2'b11 never appears. Reset leaves the block in ON with `blank_active` high. With enable and direction steady, `blank_active` then stays high for 12 cycles, counting the first cycle after reset is released.
- R2: `trip_async` passes through two synchronising flops. When it rises while the block is ON and unblanked, `drive_state` leaves ON on the third rising clock edge after the input rose.
- R3: An accepted trip starts an off period in which `drive_state` is FAST or SLOW for exactly 96 consecutive cycles, after which it returns to ON.
- R4: The decay code `decay_sel` selects how many initial off cycles are FAST: 0 for 2'b00, 14 for 2'b01, 46 for 2'b10, and 96 for 2'b11.
- R5: The rest of the off period is SLOW, and FAST never follows SLOW within one off period.
- R6: When an off period ends, `blank_active` is high for 6 cycles if `blank_long` is 0 and for 12 cycles if it is 1, while `drive_state` is ON.
- R7: A trip seen during an off period or during blanking does not start, extend or restart an off period.
- R8: If the trip is still asserted when blanking ends, the block shows exactly one unblanked ON cycle and then starts a new off period.
- R9: A change of `dir_in`, or a rising `en_in`, restarts the blanking window at its full selected length from the next cycle.
- R10: A falling `en_in` clears `blank_active` from the next cycle.
- R11: The decay code is captured when the trip is accepted. Changing `decay_sel` during an off period has no effect on that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_async | input | 1 | Sense comparator trip, asynchronous |
| decay_sel | input | 2 | Decay pattern code |
| blank_long | input | 1 | 0 selects the short blank, 1 the long blank |
| dir_in | input | 1 | Direction input |
| en_in | input | 1 | Enable input |
| drive_state | output | 2 | Drive-state code for this cycle |
| blank_active | output | 1 | Comparator is masked |

## Verification
A wrong off-counter value shows at the ports as an off period that is not 96 cycles long. A wrong captured split point shows as a FAST/SLOW boundary that has moved. Both are visible within one off period, at most 96 cycles after the trip.

A wrong blank counter, or wrong edge-detection state, shows as a masked window that is too long, too short or missing. It appears within 12 cycles of the end of an off period, a direction change or an enable edge. A synchroniser with the wrong depth moves the start of the off period by a cycle. The bench measures this from the moment the trip is raised.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    DRV_ON   = 2'b00,
    DRV_FAST = 2'b01,
    DRV_SLOW = 2'b10
  } drive_e;

  // Number of FAST cycles at the start of an off period, per decay code.
  function automatic int split_point(input logic [1:0] sel, input int lo,
                                     input int hi, input int total);
    case (sel)
      2'b00:   return 0;
      2'b01:   return lo;
      2'b10:   return hi;
      default: return total;
    endcase
  endfunction

  // Blank window length in cycles.
  function automatic int blank_len(input logic lng, input int short_len,
                                   input int long_len);
    return lng ? long_len : short_len;
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES = 96,
  parameter int SPLIT_LOW  = 14,
  parameter int SPLIT_HIGH = 46
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] decay_sel,
  output logic [1:0] drive_state,
  output logic       off_done,
  output logic       off_busy
);
  localparam int CW = $clog2(OFF_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OFF_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] split_q;
  logic          busy_q;
  drive_e        drv;

  assign off_done = busy_q && (cnt_q == LAST);
  assign off_busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      split_q <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      split_q <= CW'(split_point(decay_sel, SPLIT_LOW, SPLIT_HIGH, OFF_CYCLES));
    end else if (off_done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!busy_q)              drv = DRV_ON;
    else if (cnt_q < split_q) drv = DRV_FAST;
    else                      drv = DRV_SLOW;
  end

  assign drive_state = drv;
endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer
  import chop_pkg::*;
#(
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  input  logic blank_long,
  output logic active
);
  localparam int BW = $clog2(BLANK_LONG + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= BW'(BLANK_LONG);
    else if (clear)          cnt_q <= '0;
    else if (load)           cnt_q <= BW'(blank_len(blank_long, BLANK_SHORT, BLANK_LONG));
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES  = 96,
  parameter int SPLIT_LOW   = 14,
  parameter int SPLIT_HIGH  = 46,
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_async,
  input  logic [1:0] decay_sel,
  input  logic       blank_long,
  input  logic       dir_in,
  input  logic       en_in,
  output logic [1:0] drive_state,
  output logic       blank_active
);
  logic trip_sync;
  logic trip_accept;
  logic off_done;
  logic off_busy;
  logic dir_q, en_q;
  logic dir_change, en_rise, en_fall;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(trip_async), .q(trip_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      dir_q <= dir_in;
      en_q  <= en_in;
    end
  end

  assign dir_change  = dir_in ^ dir_q;
  assign en_rise     = en_in & ~en_q;
  assign en_fall     = ~en_in & en_q;
  assign trip_accept = trip_sync && !off_busy && !blank_active;

  chop_off_timer #(
    .OFF_CYCLES(OFF_CYCLES), .SPLIT_LOW(SPLIT_LOW), .SPLIT_HIGH(SPLIT_HIGH)
  ) u_off (
    .clk(clk), .rst_n(rst_n), .start(trip_accept), .decay_sel(decay_sel),
    .drive_state(drive_state), .off_done(off_done), .off_busy(off_busy)
  );

  chop_blank_timer #(
    .BLANK_SHORT(BLANK_SHORT), .BLANK_LONG(BLANK_LONG)
  ) u_blank (
    .clk(clk), .rst_n(rst_n),
    .load(off_done | dir_change | en_rise),
    .clear(en_fall),
    .blank_long(blank_long),
    .active(blank_active)
  );
endmodule

// File: rtl/chop_checker.sv
module chop_checker #(
  parameter int OFF_CYCLES = 96
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] drive_state,
  input logic       blank_active,
  input logic       trip_sync,
  input logic       en_in
);
  localparam int LW = $clog2(OFF_CYCLES + 2);
  logic [LW-1:0] off_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   off_len <= '0;
    else if (drive_state != 2'b00) off_len <= off_len + 1'b1;
    else                          off_len <= '0;
  end

  // R1
  code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_state != 2'b11);

  // R2
  off_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_state != 2'b00 && $past(drive_state) == 2'b00)
      |-> ($past(trip_sync) && !$past(blank_active)));

  // R3
  off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_state == 2'b00 && $past(drive_state) != 2'b00)
      |-> (off_len == LW'(OFF_CYCLES)));

  // R5
  no_fast_after_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_state == 2'b10) |=> (drive_state != 2'b01));

  // R6
  blank_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_state == 2'b00 && $past(drive_state) != 2'b00)
      |-> (blank_active || !$past(en_in)));

  // R10
  en_fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_in) && !en_in) |=> !blank_active);
endmodule

bind offtime_chopper chop_checker #(.OFF_CYCLES(OFF_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_state(drive_state),
  .blank_active(blank_active), .trip_sync(trip_sync), .en_in(en_in)
);

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trip = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic       blank_long = 1'b0;
  logic       dir_in = 1'b0;
  logic       en_in = 1'b0;
  logic [1:0] drive_state;
  logic       blank_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [1:0] ON = 2'b00, FAST = 2'b01, SLOW = 2'b10;

  offtime_chopper u_offtime_chopper (
    .clk(clk), .rst_n(rst_n), .trip_async(trip), .decay_sel(decay_sel),
    .blank_long(blank_long), .dir_in(dir_in), .en_in(en_in),
    .drive_state(drive_state), .blank_active(blank_active)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act %0d cycles exp < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (blank_active || drive_state != ON) @(negedge clk);
  endtask

  task automatic count_blank(output int nb, output bit on_ok);
    nb = 0; on_ok = 1;
    while (blank_active && nb < 50) begin
      nb++;
      if (drive_state != ON) on_ok = 0;
      @(negedge clk);
    end
  endtask

  // One trip-driven off period with the given decay code and blank length.
  task automatic off_cycle(input logic [1:0] sel, input logic lng,
                           input int exp_fast, input int exp_blank, input bit swap);
    int on_wait = 0, nf = 0, ns = 0, nb;
    bit order_ok = 1, on_ok;
    decay_sel = sel; blank_long = lng;
    wait_idle();
    trip = 1'b1;
    @(negedge clk);
    while (drive_state == ON && on_wait < 10) begin on_wait++; @(negedge clk); end
    trip = 1'b0;
    if (swap) decay_sel = ~sel;
    check(on_wait == 2, "R2 sync latency", on_wait, 2);
    while (drive_state != ON && nf + ns < 200) begin
      if (drive_state == FAST) begin nf++; if (ns != 0) order_ok = 0; end
      else if (drive_state == SLOW) ns++;
      @(negedge clk);
    end
    check(nf + ns == 96, "R3 off length", nf + ns, 96);
    check(nf == exp_fast, swap ? "R11 captured code" : "R4 fast count", nf, exp_fast);
    check(ns == 96 - exp_fast && order_ok, "R5 slow count/order", ns, 96 - exp_fast);
    count_blank(nb, on_ok);
    check(nb == exp_blank && on_ok, "R6 blank length", nb, exp_blank);
  endtask

  task automatic test_reset();
    int nb; bit on_ok;
    check(drive_state == ON && blank_active, "R1 reset state",
          {drive_state, blank_active}, {ON, 1'b1});
    count_blank(nb, on_ok);
    check(nb == 12 && on_ok, "R1 reset blank", nb, 12);
  endtask

  task automatic test_held_trip();
    int n = 0, nb; bit on_ok;
    decay_sel = 2'b01; blank_long = 1'b0;
    wait_idle();
    trip = 1'b1;
    while (drive_state == ON) @(negedge clk);
    while (drive_state != ON) begin n++; @(negedge clk); end
    check(n == 96, "R7 held trip off length", n, 96);
    count_blank(nb, on_ok);
    check(nb == 6, "R7 held trip blank", nb, 6);
    check(drive_state == ON && !blank_active, "R8 one unblanked cycle",
          drive_state, ON);
    @(negedge clk);
    check(drive_state != ON, "R8 immediate new off", drive_state, FAST);
    trip = 1'b0;
  endtask

  task automatic test_trip_in_blank();
    int n = 0;
    blank_long = 1'b1;
    wait_idle();
    dir_in = ~dir_in;
    @(negedge clk);
    trip = 1'b1;
    repeat (3) @(negedge clk);
    trip = 1'b0;
    repeat (20) begin if (drive_state != ON) n++; @(negedge clk); end
    check(n == 0, "R7 trip during blank", n, 0);
  endtask

  task automatic test_retrigger();
    int nb; bit on_ok;
    blank_long = 1'b0;
    wait_idle();
    dir_in = ~dir_in;
    @(negedge clk);
    count_blank(nb, on_ok);
    check(nb == 6, "R9 dir change blank", nb, 6);
    blank_long = 1'b1;
    en_in = 1'b0;
    repeat (3) @(negedge clk);
    en_in = 1'b1;
    @(negedge clk);
    count_blank(nb, on_ok);
    check(nb == 12, "R9 enable rise blank", nb, 12);
  endtask

  task automatic test_en_fall();
    wait_idle();
    dir_in = ~dir_in;
    repeat (3) @(negedge clk);
    check(blank_active, "R10 blank before fall", blank_active, 1);
    en_in = 1'b0;
    @(negedge clk);
    check(!blank_active, "R10 enable fall clears", blank_active, 0);
    en_in = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    en_in = 1'b1;
    @(negedge clk);
    off_cycle(2'b00, 1'b0, 0, 6, 1'b0);
    off_cycle(2'b01, 1'b1, 14, 12, 1'b0);
    off_cycle(2'b10, 1'b0, 46, 6, 1'b0);
    off_cycle(2'b11, 1'b1, 96, 12, 1'b0);
    off_cycle(2'b01, 1'b0, 14, 6, 1'b1);
    test_held_trip();
    test_trip_in_blank();
    test_retrigger();
    test_en_fall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule